// File: doc/BRIEF.md
# Dual Parallel Port Adapter

This block connects two 8-bit bidirectional parallel ports, called A and B, to a processor bus. Each port has a direction register, an output latch and a control register. The processor reaches all six registers through:

- an 8-bit data bus, split into separate write and read paths with a read-enable flag;
- a read/write line;
- a two-bit register select;
- three chip selects;
- an enable strobe that also acts as the block's only clock.

Each port has one data address, shared by its direction register and its output latch. Bit 2 of that port's control register decides which of the two the address reaches.

The two ports read back differently. A read of port A always returns the levels seen on its pins. A read of port B returns the output latch on bits set as outputs and the pin level on bits set as inputs. Both interrupt outputs are active low and stay inactive. An active-low asynchronous reset returns every register to zero, which makes every pin an input and selects the direction registers.

Top module: `dual_port_adapter`

## Requirements
- R1: While reset is low, and after it is released, every direction, output and control register holds zero: all pin output enables are 0, and a read at select 00 or 10 returns the direction register value 0x00.
- R2: The block is selected only when both active-high chip selects are 1 and the active-low chip select is 0. When the block is not selected, a write changes no register and a read does not drive the bus.
- R3: The read-enable flag is 1 exactly when the enable strobe is high, the block is selected and the read/write line is 1 (read). Otherwise it is 0.
- R4: Select 01 reaches control register A and select 11 reaches control register B. Bits 5..0 are stored on a write. Bits 7..6 always read as 0.
- R5: At select 00, when control A bit 2 is 0, the access reaches direction register A. When that bit is 1, it reaches output latch A.
- R6: At select 10, when control B bit 2 is 0, the access reaches direction register B. When that bit is 1, it reaches output latch B.
- R7: Each pin's output enable equals its direction bit (1 = output), and each pin's output value equals its output latch bit.
- R8: A read of the port A data address (control A bit 2 = 1) returns the port A pin levels on all 8 bits, including bits set as outputs.
- R9: A read of the port B data address (control B bit 2 = 1) returns the output latch bit where the direction bit is 1, and the pin level where it is 0.
- R10: A write takes effect on the falling edge of the enable strobe. While the strobe is still high in that cycle, the outputs show the old contents.
- R11: Both active-low interrupt outputs stay at 1.
- R12: Pulling reset low clears the registers at once, with no strobe edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_e | input | 1 | Enable strobe; writes are captured on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_hi0 | input | 1 | Chip select, active high |
| cs_hi1 | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| reg_sel | input | 2 | Register select |
| data_in | input | 8 | Write data from the processor |
| data_out | output | 8 | Read data to the processor |
| data_oe | output | 1 | Read data is driven on the bus |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A drive values |
| pa_oe | output | 8 | Port A per-bit output enable |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B drive values |
| pb_oe | output | 8 | Port B per-bit output enable |
| irq_a_n | output | 1 | Port A interrupt, active low, held inactive |
| irq_b_n | output | 1 | Port B interrupt, active low, held inactive |

## Verification
Read data and its enable are combinational: they are valid during the high phase of the same strobe cycle that carries the read. A write is seen on the pins, and by later reads, only from the next high phase, one falling edge later.

The bench changes inputs just after each falling edge. It compares every output against its behavioural model a quarter period after each rising edge. At that point the model holds exactly the writes of earlier cycles and none from the cycle in progress, so it matches the block in that cycle. The reset pulse in mid-cycle is checked one time unit after it is asserted, before any strobe edge.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

   typedef enum logic [1:0] {
      RS_PORT_A = 2'b00,
      RS_CTRL_A = 2'b01,
      RS_PORT_B = 2'b10,
      RS_CTRL_B = 2'b11
   } rsel_e;

   typedef struct packed {
      logic wr_ctrl;
      logic wr_data;
   } port_wr_s;

   localparam int NUM_PORTS = 2;

endpackage

// File: rtl/dpa_bus_decode.sv
module dpa_bus_decode
   import dpa_pkg::*;
#(
   parameter int NPORT = NUM_PORTS
)(
   input  logic       bus_e,
   input  logic       cs_hi0,
   input  logic       cs_hi1,
   input  logic       cs_lo_n,
   input  logic       rd_wr_n,
   input  logic [1:0] reg_sel,
   output logic       selected,
   output logic       rd_en,
   output port_wr_s   wr_port [NPORT]
);

   logic wr_cyc;

   assign selected = cs_hi0 & cs_hi1 & ~cs_lo_n;
   assign rd_en    = selected & rd_wr_n & bus_e;
   assign wr_cyc   = selected & ~rd_wr_n;

   for (genvar p = 0; p < NPORT; p++) begin : g_port_wr
      logic hit;
      assign hit                = wr_cyc & (reg_sel[1] == 1'(p));
      assign wr_port[p].wr_ctrl = hit & reg_sel[0];
      assign wr_port[p].wr_data = hit & ~reg_sel[0];
   end

endmodule

// File: rtl/dpa_port.sv
module dpa_port
   import dpa_pkg::*;
#(
   parameter int W              = 8,
   parameter int CTRL_BITS      = 6,
   parameter int SEL_BIT        = 2,
   parameter bit LATCH_READBACK = 1'b0
)(
   input  logic         bus_e,
   input  logic         rst_n,
   input  port_wr_s     wr,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] pin_in,
   output logic [W-1:0] pin_out,
   output logic [W-1:0] pin_oe,
   output logic [W-1:0] rd_ctrl,
   output logic [W-1:0] rd_port,
   output logic         data_sel
);

   localparam int PAD_BITS = W - CTRL_BITS;

   logic [W-1:0]         ddr_q;
   logic [W-1:0]         out_q;
   logic [CTRL_BITS-1:0] ctrl_q;
   logic [W-1:0]         pin_view;

   assign data_sel = ctrl_q[SEL_BIT];

   always_ff @(negedge bus_e or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr.wr_ctrl) begin
         ctrl_q <= wdata[CTRL_BITS-1:0];
      end
   end

   always_ff @(negedge bus_e or negedge rst_n) begin
      if (!rst_n) begin
         ddr_q <= '0;
      end else if (wr.wr_data && !data_sel) begin
         ddr_q <= wdata;
      end
   end

   always_ff @(negedge bus_e or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
      end else if (wr.wr_data && data_sel) begin
         out_q <= wdata;
      end
   end

   assign pin_out = out_q;
   assign pin_oe  = ddr_q;

   if (LATCH_READBACK) begin : g_latch_rb
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign pin_view[i] = ddr_q[i] ? out_q[i] : pin_in[i];
      end
   end else begin : g_pin_rb
      assign pin_view = pin_in;
   end

   assign rd_port = data_sel ? pin_view : ddr_q;

   if (PAD_BITS > 0) begin : g_ctrl_pad
      assign rd_ctrl = {{PAD_BITS{1'b0}}, ctrl_q};
   end else begin : g_ctrl_full
      assign rd_ctrl = ctrl_q;
   end

endmodule

// File: rtl/dual_port_adapter.sv
module dual_port_adapter
   import dpa_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int CTRL_BITS = 6,
   parameter int SEL_BIT   = 2
)(
   input  logic              bus_e,
   input  logic              rst_n,
   input  logic              cs_hi0,
   input  logic              cs_hi1,
   input  logic              cs_lo_n,
   input  logic              rd_wr_n,
   input  logic [1:0]        reg_sel,
   input  logic [DATA_W-1:0] data_in,
   output logic [DATA_W-1:0] data_out,
   output logic              data_oe,
   input  logic [DATA_W-1:0] pa_in,
   output logic [DATA_W-1:0] pa_out,
   output logic [DATA_W-1:0] pa_oe,
   input  logic [DATA_W-1:0] pb_in,
   output logic [DATA_W-1:0] pb_out,
   output logic [DATA_W-1:0] pb_oe,
   output logic              irq_a_n,
   output logic              irq_b_n
);

   if (CTRL_BITS > DATA_W) begin : g_chk_ctrl
      $error("CTRL_BITS must not exceed DATA_W");
   end
   if (SEL_BIT >= CTRL_BITS) begin : g_chk_sel
      $error("SEL_BIT must lie inside the stored control bits");
   end

   logic        dev_sel;
   logic        rd_en;
   port_wr_s    wr_port [NUM_PORTS];
   logic [DATA_W-1:0] rd_ctrl_a, rd_ctrl_b, rd_port_a, rd_port_b;
   logic        a_data_sel, b_data_sel;
   rsel_e       rs;

   dpa_bus_decode #(.NPORT(NUM_PORTS)) u_dec (
      .bus_e    (bus_e),
      .cs_hi0   (cs_hi0),
      .cs_hi1   (cs_hi1),
      .cs_lo_n  (cs_lo_n),
      .rd_wr_n  (rd_wr_n),
      .reg_sel  (reg_sel),
      .selected (dev_sel),
      .rd_en    (rd_en),
      .wr_port  (wr_port)
   );

   dpa_port #(
      .W(DATA_W), .CTRL_BITS(CTRL_BITS), .SEL_BIT(SEL_BIT), .LATCH_READBACK(1'b0)
   ) u_port_a (
      .bus_e    (bus_e),
      .rst_n    (rst_n),
      .wr       (wr_port[0]),
      .wdata    (data_in),
      .pin_in   (pa_in),
      .pin_out  (pa_out),
      .pin_oe   (pa_oe),
      .rd_ctrl  (rd_ctrl_a),
      .rd_port  (rd_port_a),
      .data_sel (a_data_sel)
   );

   dpa_port #(
      .W(DATA_W), .CTRL_BITS(CTRL_BITS), .SEL_BIT(SEL_BIT), .LATCH_READBACK(1'b1)
   ) u_port_b (
      .bus_e    (bus_e),
      .rst_n    (rst_n),
      .wr       (wr_port[1]),
      .wdata    (data_in),
      .pin_in   (pb_in),
      .pin_out  (pb_out),
      .pin_oe   (pb_oe),
      .rd_ctrl  (rd_ctrl_b),
      .rd_port  (rd_port_b),
      .data_sel (b_data_sel)
   );

   assign rs = rsel_e'(reg_sel);

   always_comb begin
      data_out = '0;
      if (rd_en) begin
         unique case (rs)
            RS_PORT_A: data_out = rd_port_a;
            RS_CTRL_A: data_out = rd_ctrl_a;
            RS_PORT_B: data_out = rd_port_b;
            RS_CTRL_B: data_out = rd_ctrl_b;
            default:   data_out = '0;
         endcase
      end
   end

   assign data_oe = rd_en;
   assign irq_a_n = 1'b1;
   assign irq_b_n = 1'b1;

endmodule

// File: rtl/dpa_checker.sv
module dpa_checker #(
   parameter int W = 8
)(
   input logic         bus_e,
   input logic         rst_n,
   input logic         selected,
   input logic         rd_wr_n,
   input logic [1:0]   reg_sel,
   input logic [W-1:0] data_in,
   input logic [W-1:0] data_out,
   input logic         data_oe,
   input logic         a_data_sel,
   input logic         b_data_sel,
   input logic [W-1:0] pa_in,
   input logic [W-1:0] pa_out,
   input logic [W-1:0] pa_oe,
   input logic [W-1:0] pb_in,
   input logic [W-1:0] pb_out,
   input logic [W-1:0] pb_oe
);

   // R3: the bus is driven only for a selected read
   p_oe_gate_r3: assert property (@(negedge bus_e) disable iff (!rst_n)
      data_oe |-> (selected && rd_wr_n));

   // R2: cycles that are not selected writes leave the pin state alone
   p_no_write_hold_r2: assert property (@(negedge bus_e) disable iff (!rst_n)
      (!selected || rd_wr_n) |=> ($stable(pa_oe) && $stable(pb_oe)
                                  && $stable(pa_out) && $stable(pb_out)));

   // R4: upper control bits read as zero
   p_ctrl_top_zero_r4: assert property (@(negedge bus_e) disable iff (!rst_n)
      (data_oe && reg_sel[0]) |-> (data_out[W-1:W-2] == 2'b00));

   // R8: port A data read mirrors the pins
   p_pa_pins_r8: assert property (@(negedge bus_e) disable iff (!rst_n)
      (data_oe && reg_sel == 2'b00 && a_data_sel) |-> (data_out == pa_in));

   // R9: port B input bits read the pins, output bits the latch
   p_pb_mix_r9: assert property (@(negedge bus_e) disable iff (!rst_n)
      (data_oe && reg_sel == 2'b10 && b_data_sel) |->
         (((data_out & ~pb_oe) == (pb_in & ~pb_oe))
          && ((data_out & pb_oe) == (pb_out & pb_oe))));

   // R10: a direction write shows up after the falling edge
   p_ddr_write_r10: assert property (@(negedge bus_e) disable iff (!rst_n)
      (selected && !rd_wr_n && reg_sel == 2'b00 && !a_data_sel)
         |=> (pa_oe == $past(data_in)));

endmodule

bind dual_port_adapter dpa_checker #(.W(DATA_W)) u_dpa_chk (
   .bus_e      (bus_e),
   .rst_n      (rst_n),
   .selected   (dev_sel),
   .rd_wr_n    (rd_wr_n),
   .reg_sel    (reg_sel),
   .data_in    (data_in),
   .data_out   (data_out),
   .data_oe    (data_oe),
   .a_data_sel (a_data_sel),
   .b_data_sel (b_data_sel),
   .pa_in      (pa_in),
   .pa_out     (pa_out),
   .pa_oe      (pa_oe),
   .pb_in      (pb_in),
   .pb_out     (pb_out),
   .pb_oe      (pb_oe)
);

// File: tb/test_dual_port_adapter.sv
module test_dual_port_adapter;

   localparam int E_PERIOD = 20;

   logic       e = 1'b0;
   logic       rst_n = 1'b1;
   logic       cs0 = 1'b0, cs1 = 1'b0, cs2n = 1'b1;
   logic       rw = 1'b1;
   logic [1:0] rs = 2'b00;
   logic [7:0] wd = 8'h00;
   logic [7:0] pa_pin = 8'h3C, pb_pin = 8'h5A;
   logic [7:0] data_out, pa_out, pa_oe, pb_out, pb_oe;
   logic       data_oe, irq_a_n, irq_b_n;

   int n_chk = 0;
   int n_fail = 0;

   // behavioural model state
   logic [7:0] m_ddr_a = 8'h00, m_out_a = 8'h00, m_ddr_b = 8'h00, m_out_b = 8'h00;
   logic [5:0] m_cr_a = 6'h00, m_cr_b = 6'h00;

   always #(E_PERIOD/2) e = ~e;

   dual_port_adapter i_dual_port_adapter (
      .bus_e(e), .rst_n(rst_n), .cs_hi0(cs0), .cs_hi1(cs1), .cs_lo_n(cs2n),
      .rd_wr_n(rw), .reg_sel(rs), .data_in(wd), .data_out(data_out),
      .data_oe(data_oe), .pa_in(pa_pin), .pa_out(pa_out), .pa_oe(pa_oe),
      .pb_in(pb_pin), .pb_out(pb_out), .pb_oe(pb_oe),
      .irq_a_n(irq_a_n), .irq_b_n(irq_b_n)
   );

   task automatic chk(input bit ok, input string req, input logic [7:0] act,
                      input logic [7:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit is_sel();
      return cs0 && cs1 && !cs2n;
   endfunction

   // model update: writes commit on the falling strobe edge
   always @(negedge e or negedge rst_n) begin
      if (!rst_n) begin
         m_ddr_a = 0; m_out_a = 0; m_ddr_b = 0; m_out_b = 0; m_cr_a = 0; m_cr_b = 0;
      end else if (is_sel() && !rw) begin
         case (rs)
            2'b01: m_cr_a = wd[5:0];
            2'b11: m_cr_b = wd[5:0];
            2'b00: if (m_cr_a[2]) m_out_a = wd; else m_ddr_a = wd;
            default: if (m_cr_b[2]) m_out_b = wd; else m_ddr_b = wd;
         endcase
      end
   end

   // compare on every cycle, a quarter period into the high phase
   always @(posedge e) begin
      logic [7:0] exp_rd;
      string      tag;
      #(E_PERIOD/4);
      chk(pa_oe == m_ddr_a, "R7 R10 pa_oe", pa_oe, m_ddr_a);
      chk(pa_out == m_out_a, "R7 R10 pa_out", pa_out, m_out_a);
      chk(pb_oe == m_ddr_b, "R7 R10 pb_oe", pb_oe, m_ddr_b);
      chk(pb_out == m_out_b, "R7 R10 pb_out", pb_out, m_out_b);
      chk(irq_a_n && irq_b_n, "R11 irq", {6'b0, irq_a_n, irq_b_n}, 8'h03);
      chk(data_oe == (is_sel() && rw), "R3 R2 data_oe", {7'b0, data_oe},
          {7'b0, is_sel() && rw});
      if (is_sel() && rw) begin
         case (rs)
            2'b01: begin exp_rd = {2'b00, m_cr_a}; tag = "R4 ctrl A"; end
            2'b11: begin exp_rd = {2'b00, m_cr_b}; tag = "R4 ctrl B"; end
            2'b00: begin
               if (m_cr_a[2]) begin exp_rd = pa_pin;  tag = "R8 port A data"; end
               else           begin exp_rd = m_ddr_a; tag = "R5 R1 ddr A"; end
            end
            default: begin
               if (m_cr_b[2]) begin
                  exp_rd = (m_ddr_b & m_out_b) | (~m_ddr_b & pb_pin);
                  tag = "R9 port B data";
               end else begin exp_rd = m_ddr_b; tag = "R6 R1 ddr B"; end
            end
         endcase
         chk(data_out == exp_rd, tag, data_out, exp_rd);
      end
   end

   task automatic cyc(input bit a, input bit b, input bit n, input bit rw_i,
                      input logic [1:0] rs_i, input logic [7:0] d);
      cs0 = a; cs1 = b; cs2n = n; rw = rw_i; rs = rs_i; wd = d;
      @(negedge e); #1;
   endtask

   task automatic wr(input logic [1:0] r, input logic [7:0] d);
      cyc(1, 1, 0, 0, r, d);
   endtask

   task automatic rd(input logic [1:0] r);
      cyc(1, 1, 0, 1, r, 8'h00);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #(E_PERIOD * 50000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=00 expected=01");
      summary();
      $finish;
   end

   initial begin
      #1 rst_n = 1'b0;
      #2;
      // R1: reset state at the pins
      chk(pa_oe == 8'h00 && pb_oe == 8'h00, "R1 reset oe", pa_oe | pb_oe, 8'h00);
      repeat (2) @(negedge e);
      #1 rst_n = 1'b1;
      // R1 / R5 / R6: after reset, data addresses reach the direction registers
      rd(2'b00); rd(2'b10); rd(2'b01); rd(2'b11);
      // R5: direction register A, then switch to output latch A
      wr(2'b00, 8'hF0);
      rd(2'b00);
      wr(2'b01, 8'hFF);            // R4: only bits 5..0 kept
      rd(2'b01);
      wr(2'b00, 8'hA5);            // output latch A
      rd(2'b00);                   // R8: pins, not latch
      pa_pin = 8'hC3;
      rd(2'b00);
      // R2: each missing chip select blocks writes and reads
      cyc(0, 1, 0, 0, 2'b01, 8'h00);
      cyc(1, 0, 0, 0, 2'b00, 8'h11);
      cyc(1, 1, 1, 0, 2'b01, 8'h00);
      cyc(1, 1, 1, 1, 2'b00, 8'h00);
      rd(2'b01);
      // R6 / R9: port B mixed direction
      wr(2'b10, 8'h0F);
      rd(2'b10);
      wr(2'b11, 8'h04);
      rd(2'b11);
      wr(2'b10, 8'h96);
      rd(2'b10);
      pb_pin = 8'hA7;
      rd(2'b10);
      wr(2'b11, 8'h00);
      rd(2'b10);                   // back to direction register B
      // R10: write in one cycle, idle the next, read after
      wr(2'b01, 8'h00);
      wr(2'b00, 8'h3C);
      cyc(0, 0, 1, 1, 2'b00, 8'h00);
      rd(2'b00);
      // R12: asynchronous reset in mid high phase
      @(posedge e); #2;
      rst_n = 1'b0;
      #1;
      chk(pa_oe == 8'h00 && pb_oe == 8'h00 && pb_out == 8'h00,
          "R12 async clear", pa_oe | pb_oe | pb_out, 8'h00);
      @(negedge e); #1;
      rst_n = 1'b1;
      rd(2'b01); rd(2'b00); rd(2'b10);
      summary();
      $finish;
   end

endmodule